// File: doc/BRIEF.md
# Buffered Configuration Port Transfer Engine

This block sits between a word-oriented host bus and an internal configuration port. A 512-word buffer RAM fills the low part of the host address map. Four control words sit just above it. Software loads the buffer and programs a length in bytes and a starting buffer word. It then writes a direction word, and that write alone launches the transfer. In configure mode the engine streams buffer words to the port. In readback mode it stores words arriving from the port into the buffer. Software then reads the buffer.

A status word carries the completion flag, four bits that always read as one, and four condition flags taken from the port. A write to the status address aborts any running transfer and pulses a reset toward the port. Both port directions use a 32-bit valid/ready handshake, and a word moves on every cycle where both sides agree.

Top module: `cfg_xfer_engine`

## Requirements
- R1: Buffer word N (0..511) is written and read at byte address N*4 (address bit 11 low). Read data appears on `host_rdata` with `host_rvalid` high in the cycle after `host_rd`.
- R2: The length word at 0x800 reads back all 32 bits written to it. The start-word register at 0x804 keeps bits 8:0 of the written value and reads back zero-extended.
- R3: A write to 0x808 launches a transfer. Write-data bit 0 = 1 selects readback and 0 selects configure. Reads of 0x808, and reads of any other address from 0x810 up to 0xFFC, return zero.
- R4: In configure mode, length>>2 words leave on `port_tx_data` in buffer order from the start word, one per handshake. While `port_tx_ready` is low, `port_tx_valid` stays high and the data stays unchanged.
- R5: In readback mode `port_rx_ready` is high, and each accepted `port_rx_data` word is stored at the start word plus its position in the sequence.
- R6: Status bit 0 (done) reads 1 after reset, reads 0 from the cycle after a launch, and reads 1 again once the final word has moved. A launch with a length below 4 leaves done at 1 and produces no port activity.
- R7: Status bits 4:1 read 1 and bits 31:9 read 0. Once the port flags have been steady for two cycles, bit 8 = `port_cfg_err`, bit 7 = `port_aligned`, bit 6 = `port_rb_active` and bit 5 = `port_abort_n`.
- R8: A write to 0x80C stops any transfer. In the next cycle done reads 1, the port signals go idle, and `port_rst` is high for exactly one cycle.
- R9: While a transfer runs, writes to the length, start-word and direction registers and to the buffer are ignored.
- R10: Buffer word addresses generated by a transfer wrap from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 12 | Host byte address |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the strobe |
| host_rvalid | output | 1 | Marks valid read data |
| port_tx_data | output | 32 | Word sent to the port in configure mode |
| port_tx_valid | output | 1 | Outgoing word valid |
| port_tx_ready | input | 1 | Port accepts the outgoing word |
| port_rx_data | input | 32 | Word from the port in readback mode |
| port_rx_valid | input | 1 | Incoming word valid |
| port_rx_ready | output | 1 | Engine accepts the incoming word |
| port_cfg_err | input | 1 | Port configuration error flag |
| port_aligned | input | 1 | Port data-aligned flag |
| port_rb_active | input | 1 | Port readback-in-progress flag |
| port_abort_n | input | 1 | Port abort-in-progress flag, active low |
| port_rst | output | 1 | One-cycle reset pulse toward the port |

## Verification
During a configure transfer, the buffer RAM can serve a host read and a streaming fetch in the same cycle. Each uses its own read port on the shared array. The bench provokes this by reading a buffer word while the port applies one-in-three backpressure. It judges the result twice. The host read must return the model value of that word, and the scoreboard must see every streamed word unchanged and in order. In the same window, a buffer write and a length write must both be dropped, and readback of those locations after completion shows this.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int DATA_W = 32;

    // register index, host byte address bits 3:2 inside the control window
    localparam logic [1:0] RIDX_LEN  = 2'd0;
    localparam logic [1:0] RIDX_BASE = 2'd1;
    localparam logic [1:0] RIDX_DIR  = 2'd2;
    localparam logic [1:0] RIDX_STAT = 2'd3;

    localparam logic [3:0] STAT_FILL = 4'b1111;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CFG  = 2'd1,
        SQ_RB   = 2'd2
    } sq_state_e;
endpackage

// File: rtl/cfgx_ram.sv
module cfgx_ram #(
    parameter int WORDS = 512,
    parameter int AW    = 9,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] h_addr,
    input  logic          h_we,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_q,
    input  logic [AW-1:0] e_raddr,
    output logic [DW-1:0] e_q,
    input  logic          e_we,
    input  logic [AW-1:0] e_waddr,
    input  logic [DW-1:0] e_wdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        h_q <= mem[h_addr];
        e_q <= mem[e_raddr];
        if (e_we) begin
            mem[e_waddr] <= e_wdata;
        end else if (h_we) begin
            mem[h_addr] <= h_wdata;
        end
    end

    // the register block blocks host writes whenever the engine may write
    assert_no_dual_write_R9: assert property (@(posedge clk) !(e_we && h_we));
endmodule

// File: rtl/cfgx_regs.sv
module cfgx_regs
    import cfgx_pkg::*;
#(
    parameter int AW   = 9,
    parameter int HA_W = AW + 3,
    parameter int CW   = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HA_W-1:0]   host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic              busy,
    input  logic              done,
    input  logic [3:0]        flag_in,
    input  logic [DATA_W-1:0] ram_hq,
    output logic              buf_we,
    output logic [AW-1:0]     buf_addr,
    output logic              start,
    output logic              start_rb,
    output logic [CW-1:0]     start_words,
    output logic [AW-1:0]     start_ptr,
    output logic              kill,
    output logic              port_rst
);
    typedef struct packed {
        logic [DATA_W-1:0] len;
        logic [AW-1:0]     base;
        logic [3:0]        flags;
        logic [DATA_W-1:0] rdata;
        logic              rsel_buf;
        logic              rvalid;
        logic              prst;
    } regs_t;

    regs_t q, d;

    logic       in_buf;
    logic       in_regs;
    logic [1:0] idx;
    logic [DATA_W-1:0] stat_word;

    assign in_buf    = !host_addr[HA_W-1];
    assign in_regs   = host_addr[HA_W-1] && (host_addr[HA_W-2:4] == '0);
    assign idx       = host_addr[3:2];
    assign stat_word = {{(DATA_W-9){1'b0}}, q.flags, STAT_FILL, done};

    always_comb begin
        d          = q;
        d.flags    = flag_in;
        d.prst     = 1'b0;
        d.rvalid   = host_rd;
        d.rsel_buf = host_rd && in_buf;
        if (host_wr && in_regs) begin
            unique case (idx)
                RIDX_LEN:  if (!busy) d.len  = host_wdata;
                RIDX_BASE: if (!busy) d.base = host_wdata[AW-1:0];
                RIDX_STAT: d.prst = 1'b1;
                default:   ;
            endcase
        end
        if (host_rd) begin
            d.rdata = '0;
            if (in_regs) begin
                unique case (idx)
                    RIDX_LEN:  d.rdata = q.len;
                    RIDX_BASE: d.rdata = DATA_W'(q.base);
                    RIDX_STAT: d.rdata = stat_word;
                    default:   d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign buf_we      = host_wr && in_buf && !busy;
    assign buf_addr    = host_addr[AW+1:2];
    assign start       = host_wr && in_regs && (idx == RIDX_DIR) && !busy;
    assign start_rb    = host_wdata[0];
    assign start_words = q.len[DATA_W-1:2];
    assign start_ptr   = q.base;
    assign kill        = host_wr && in_regs && (idx == RIDX_STAT);
    assign port_rst    = q.prst;
    assign host_rdata  = q.rsel_buf ? ram_hq : q.rdata;
    assign host_rvalid = q.rvalid;

    assert_len_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && in_regs && idx == RIDX_LEN) |=> $stable(q.len));
    assert_base_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && in_regs && idx == RIDX_BASE) |=> $stable(q.base));
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
    import cfgx_pkg::*;
#(
    parameter int AW = 9,
    parameter int CW = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rb,
    input  logic [CW-1:0]     start_words,
    input  logic [AW-1:0]     start_ptr,
    input  logic              kill,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              tx_valid,
    output logic              rx_ready,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        sq_state_e     state;
        logic [AW-1:0] ptr;
        logic [CW-1:0] left;
        logic          done;
    } seq_t;

    seq_t q, d;
    logic step;

    assign step = ((q.state == SQ_CFG) && tx_ready) || ((q.state == SQ_RB) && rx_valid);

    always_comb begin
        d = q;
        unique case (q.state)
            SQ_IDLE: begin
                if (start && (start_words != '0)) begin
                    d.state = start_rb ? SQ_RB : SQ_CFG;
                    d.ptr   = start_ptr;
                    d.left  = start_words;
                    d.done  = 1'b0;
                end
            end
            SQ_CFG, SQ_RB: begin
                if (step) begin
                    d.ptr  = q.ptr + 1'b1;
                    d.left = q.left - 1'b1;
                    if (q.left == CW'(1)) begin
                        d.state = SQ_IDLE;
                        d.done  = 1'b1;
                    end
                end
            end
            default: d.state = SQ_IDLE;
        endcase
        if (kill) begin
            d.state = SQ_IDLE;
            d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= SQ_IDLE;
            q.ptr   <= '0;
            q.left  <= '0;
            q.done  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_valid = (q.state == SQ_CFG);
    assign rx_ready = (q.state == SQ_RB);
    assign busy     = (q.state != SQ_IDLE);
    assign done     = q.done;
    assign rd_addr  = d.ptr;
    assign wr_en    = rx_ready && rx_valid && !kill;
    assign wr_addr  = q.ptr;
    assign wr_data  = rx_data;

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (done && !busy));
    assert_launch_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_words != '0 && !kill) |=> (!done && busy));
    assert_short_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_words == '0 && !kill) |=> (done && !busy));
endmodule

// File: rtl/cfg_xfer_engine.sv
module cfg_xfer_engine
    import cfgx_pkg::*;
#(
    parameter  int BUF_WORDS = 512,
    localparam int AW        = $clog2(BUF_WORDS),
    localparam int HA_W      = AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HA_W-1:0]   host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] port_tx_data,
    output logic              port_tx_valid,
    input  logic              port_tx_ready,
    input  logic [DATA_W-1:0] port_rx_data,
    input  logic              port_rx_valid,
    output logic              port_rx_ready,
    input  logic              port_cfg_err,
    input  logic              port_aligned,
    input  logic              port_rb_active,
    input  logic              port_abort_n,
    output logic              port_rst
);
    localparam int CW = DATA_W - 2;

    logic              busy, done, start, start_rb, kill;
    logic [CW-1:0]     start_words;
    logic [AW-1:0]     start_ptr;
    logic              buf_we;
    logic [AW-1:0]     buf_addr;
    logic [DATA_W-1:0] ram_hq;
    logic [AW-1:0]     eng_raddr, eng_waddr;
    logic              eng_we;
    logic [DATA_W-1:0] eng_wdata;

    cfgx_regs #(.AW(AW), .HA_W(HA_W), .CW(CW)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .busy        (busy),
        .done        (done),
        .flag_in     ({port_cfg_err, port_aligned, port_rb_active, port_abort_n}),
        .ram_hq      (ram_hq),
        .buf_we      (buf_we),
        .buf_addr    (buf_addr),
        .start       (start),
        .start_rb    (start_rb),
        .start_words (start_words),
        .start_ptr   (start_ptr),
        .kill        (kill),
        .port_rst    (port_rst)
    );

    cfgx_seq #(.AW(AW), .CW(CW)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_rb    (start_rb),
        .start_words (start_words),
        .start_ptr   (start_ptr),
        .kill        (kill),
        .tx_ready    (port_tx_ready),
        .rx_valid    (port_rx_valid),
        .rx_data     (port_rx_data),
        .tx_valid    (port_tx_valid),
        .rx_ready    (port_rx_ready),
        .busy        (busy),
        .done        (done),
        .rd_addr     (eng_raddr),
        .wr_en       (eng_we),
        .wr_addr     (eng_waddr),
        .wr_data     (eng_wdata)
    );

    cfgx_ram #(.WORDS(BUF_WORDS), .AW(AW), .DW(DATA_W)) ram_i (
        .clk     (clk),
        .h_addr  (buf_addr),
        .h_we    (buf_we),
        .h_wdata (host_wdata),
        .h_q     (ram_hq),
        .e_raddr (eng_raddr),
        .e_q     (port_tx_data),
        .e_we    (eng_we),
        .e_waddr (eng_waddr),
        .e_wdata (eng_wdata)
    );

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_tx_valid && !port_tx_ready && !kill) |=> (port_tx_valid && $stable(port_tx_data)));
    assert_one_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_tx_valid && port_rx_ready));
endmodule

// File: tb/cfg_xfer_engine_tb.sv
module cfg_xfer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [31:0] port_tx_data;
    logic        port_tx_valid;
    logic        port_tx_ready = 1'b0;
    logic [31:0] port_rx_data = '0;
    logic        port_rx_valid = 1'b0;
    logic        port_rx_ready;
    logic        port_cfg_err = 1'b0;
    logic        port_aligned = 1'b1;
    logic        port_rb_active = 1'b0;
    logic        port_abort_n = 1'b1;
    logic        port_rst;

    always #4 clk = ~clk;

    cfg_xfer_engine dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .port_tx_data(port_tx_data), .port_tx_valid(port_tx_valid), .port_tx_ready(port_tx_ready),
        .port_rx_data(port_rx_data), .port_rx_valid(port_rx_valid), .port_rx_ready(port_rx_ready),
        .port_cfg_err(port_cfg_err), .port_aligned(port_aligned), .port_rb_active(port_rb_active),
        .port_abort_n(port_abort_n), .port_rst(port_rst)
    );

    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          rdy_mode = 0;   // 0 held low, 1 one cycle in three, 2 always
    bit          rx_en = 1'b0;
    int          rb_idx = 0;
    int          rb_n = 0;
    int          tx_seen = 0;
    logic [31:0] rb_src [4];
    logic [31:0] model [512];
    logic [31:0] exp_q [$];
    logic [31:0] rd_val;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rvalid ? host_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic buf_load(input int w, input logic [31:0] v);
        host_write(12'(w * 4), v);
        model[w] = v;
    endtask

    // driver side of the scoreboard: expected outgoing words
    task automatic push_cfg(input int base, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(model[(base + i) % 512]);
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        int tries = 0;
        do begin
            host_read(12'h80C, s);
            tries++;
        end while (!s[0] && tries < 200);
        check(s[0] == 1'b1, req, s, 32'h1);
    endtask

    // port model and scoreboard monitor
    always @(negedge clk) begin
        bit r;
        logic [31:0] e;
        cyc++;
        case (rdy_mode)
            0: r = 1'b0;
            1: r = (cyc % 3 == 0);
            default: r = 1'b1;
        endcase
        if (rst_n && port_tx_valid && r) begin
            tx_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected outgoing word", port_tx_data, 32'h0);
            end else begin
                e = exp_q.pop_front();
                check(port_tx_data == e, "R4/R10 outgoing word", port_tx_data, e);
            end
        end
        port_tx_ready = r;
        if (rx_en && rb_idx < rb_n && cyc[0]) begin
            port_rx_valid = 1'b1;
            port_rx_data  = rb_src[rb_idx];
        end else begin
            port_rx_valid = 1'b0;
            port_rx_data  = '0;
        end
        if (port_rx_valid && port_rx_ready) rb_idx++;
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // reset state
        check(!port_tx_valid && !port_rx_ready && !port_rst, "R6 idle port after reset",
              {29'b0, port_tx_valid, port_rx_ready, port_rst}, 32'h0);
        host_read(12'h80C, rd_val);
        check(rd_val == 32'h0000_00BF, "R6/R7 status after reset", rd_val, 32'h0000_00BF);

        // buffer access
        for (int i = 0; i < 16; i++) buf_load(i, 32'hC0DE_0000 + 32'(i * 17));
        buf_load(20, 32'h2020_2020);
        buf_load(100, 32'h1001_1001);
        buf_load(510, 32'h5100_0510);
        buf_load(511, 32'h5110_0511);
        host_read(12'h01C, rd_val);
        check(rd_val == model[7], "R1 buffer word 7", rd_val, model[7]);
        host_read(12'h7FC, rd_val);
        check(rd_val == model[511], "R1 buffer word 511", rd_val, model[511]);

        // register access
        host_write(12'h800, 32'hA5A5_0103);
        host_read(12'h800, rd_val);
        check(rd_val == 32'hA5A5_0103, "R2 length readback", rd_val, 32'hA5A5_0103);
        host_write(12'h804, 32'h0000_1234);
        host_read(12'h804, rd_val);
        check(rd_val == 32'h0000_0034, "R2 start word readback", rd_val, 32'h0000_0034);
        host_read(12'h808, rd_val);
        check(rd_val == 32'h0, "R3 direction reads zero", rd_val, 32'h0);
        host_read(12'h810, rd_val);
        check(rd_val == 32'h0, "R3 unmapped reads zero", rd_val, 32'h0);

        // configure, 8 words from word 4, length 35 bytes, backpressure
        host_write(12'h800, 32'd35);
        host_write(12'h804, 32'd4);
        push_cfg(4, 8);
        rdy_mode = 1;
        tx_seen = 0;
        host_write(12'h808, 32'h0);
        host_read(12'h80C, rd_val);
        check(rd_val[0] == 1'b0, "R6 done low while running", rd_val, {rd_val[31:1], 1'b0});
        host_write(12'h800, 32'd400);
        host_write(12'h190, 32'hFFFF_0000);
        host_read(12'h050, rd_val);
        check(rd_val == model[20], "R1 host read during streaming", rd_val, model[20]);
        wait_done("R6 configure completes");
        check(tx_seen == 8, "R4 word count from length>>2", 32'(tx_seen), 32'd8);
        check(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
        host_read(12'h800, rd_val);
        check(rd_val == 32'd35, "R9 length write ignored while busy", rd_val, 32'd35);
        host_read(12'h190, rd_val);
        check(rd_val == model[100], "R9 buffer write ignored while busy", rd_val, model[100]);

        // configure with wrap
        host_write(12'h800, 32'd16);
        host_write(12'h804, 32'd510);
        push_cfg(510, 4);
        rdy_mode = 2;
        tx_seen = 0;
        host_write(12'h808, 32'h0);
        wait_done("R10 wrap configure completes");
        check(tx_seen == 4, "R10 wrap word count", 32'(tx_seen), 32'd4);

        // readback with wrap
        rdy_mode = 0;
        for (int i = 0; i < 4; i++) rb_src[i] = 32'hB0B0_0000 + 32'(i);
        rb_idx = 0; rb_n = 4; rx_en = 1'b1;
        host_write(12'h808, 32'h1);
        wait_done("R5 readback completes");
        rx_en = 1'b0;
        for (int i = 0; i < 4; i++) model[(510 + i) % 512] = rb_src[i];
        for (int i = 0; i < 5; i++) begin
            int w = (510 + i) % 512;
            host_read(12'(w * 4), rd_val);
            check(rd_val == model[w], "R5/R10 readback stored word", rd_val, model[w]);
        end

        // short length: no transfer
        host_write(12'h800, 32'd3);
        tx_seen = 0;
        rdy_mode = 2;
        host_write(12'h808, 32'h0);
        check(!port_tx_valid, "R6 short length no port activity", {31'b0, port_tx_valid}, 32'h0);
        host_read(12'h80C, rd_val);
        check(rd_val[0] == 1'b1, "R6 short length done stays high", rd_val, {rd_val[31:1], 1'b1});
        check(tx_seen == 0, "R6 short length no words", 32'(tx_seen), 32'h0);

        // abort a stalled configure
        rdy_mode = 0;
        host_write(12'h800, 32'd256);
        host_write(12'h804, 32'd0);
        host_write(12'h808, 32'h0);
        repeat (3) @(negedge clk);
        check(port_tx_valid, "R4 stalled word held", {31'b0, port_tx_valid}, 32'h1);
        host_write(12'h80C, 32'h0000_FEFE);
        check(port_rst && !port_tx_valid, "R8 port reset pulse and idle",
              {30'b0, port_rst, port_tx_valid}, 32'h2);
        @(negedge clk);
        check(!port_rst, "R8 port reset one cycle", {31'b0, port_rst}, 32'h0);
        host_read(12'h80C, rd_val);
        check(rd_val[0] == 1'b1, "R8 done after abort", rd_val, {rd_val[31:1], 1'b1});

        // port flag mapping
        port_cfg_err = 1'b1; port_aligned = 1'b0; port_rb_active = 1'b1; port_abort_n = 1'b0;
        repeat (2) @(negedge clk);
        host_read(12'h80C, rd_val);
        check(rd_val == 32'h0000_015F, "R7 flag bits", rd_val, 32'h0000_015F);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule